// File: doc/BRIEF.md
# Serial Display Frame Loader

This block takes display and setting bits from a host over three wires (an enable line, a serial clock and a data line) and holds them in a 204-bit segment store plus eight setting bits for a 4-common LCD driver. All three inputs are brought into the fast system clock through two-flop synchronisers. Rising serial clock edges are then found in that domain. While the enable line is low, the block collects a device address. When enable goes high, a burst of data bits is accepted only if the last eight address bits equal 0x41.

Each burst is one 64-bit chunk. The top two bits of the chunk say which quarter of the segment store it fills. A small panel sends only the first one, two or three chunks. The first chunk, which carries segments D1 to D52 and the settings, is always sent. Nothing reaches the outputs until enable falls. At that point the chunk is written, but only if exactly 64 bits arrived.

The controller has four states. ADDR_WAIT collects address bits and is the reset state. CAPTURE collects data bits after a matching address. DISCARD lets a burst under a foreign address pass without effect. COMMIT lasts one cycle and writes the chunk. The transitions are:
- ADDR_WAIT to CAPTURE on an enable rise with a matching address.
- ADDR_WAIT to DISCARD on an enable rise with any other address.
- CAPTURE to COMMIT on an enable fall.
- DISCARD to ADDR_WAIT on an enable fall.
- COMMIT to ADDR_WAIT unconditionally.

Top module: `lcd_serial_loader`

## Requirements
- R1: After reset every segment bit and every setting output is 0.
- R2: Address bits are taken on rising serial clock edges while enable is low, first bit received as bit 0. A burst is accepted only when the address held at the enable rise is 0x41; a burst under any other address leaves every output unchanged.
- R3: Data bits are taken on rising serial clock edges while enable is high, and the k-th bit received (counting from 0) becomes chunk bit k.
- R4: Chunk bits 63:62 form the chunk number (bit 63 the MSB). Chunk 0 writes D1..D52 from bits 51:0 and the settings from bits 52..59, in this order: low-current select, port select bits 0..3, half-bias select, segment-off, power-save. Chunk 1 writes D53..D104 from bits 51:0. Chunk 2 writes D105..D156 from bits 51:0. Chunk 3 writes D157..D204 from bits 47:0. Bits 61:60 of every chunk, and bits 51:48 of chunk 3, are ignored.
- R5: A chunk is written only after an enable fall, and only when exactly 64 data bits arrived; a burst of 63 or 65 bits leaves every output unchanged.
- R6: A write touches only the segment range (and, for chunk 0, the settings) of its own chunk number; the rest keeps its value, so a partial update with chunk 0 alone is possible.
- R7: Outputs do not change during an address phase or a data burst; they change at most once, in the cycle after the commit state.
- R8: Transfers work both with the serial clock resting low and with it resting high while enable changes.
- R9: The address store is cleared at every enable fall, so a burst sent without a fresh address phase is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Serial enable: low for address, high for data |
| sclk_i | input | 1 | Serial clock, bits taken on its rising edge |
| sdi_i | input | 1 | Serial data |
| disp_o | output | 204 | Segment store, bit n-1 holds Dn |
| cur_low_o | output | 1 | Low-current drive select |
| port_sel_o | output | 4 | Count of leading pins used as plain ports (bit 0 first received) |
| bias_half_o | output | 1 | 1 selects half bias, 0 third bias |
| seg_off_o | output | 1 | Segments forced off |
| save_mode_o | output | 1 | Power-save mode |

## Verification
The assertions check several relations on every cycle. Outputs hold outside the commit state. A commit with a bit count other than 64 leaves the outputs unchanged. The capture state is entered only from an address store holding 0x41. A chunk-0 commit places the received setting bits on the setting outputs. The bit counter never runs past its saturation value. Only the bench scenarios can show the parts that depend on a whole serial sequence and on stored history: LSB-first ordering, the routing of each chunk number to its range, padding that is ignored, both resting levels of the serial clock, and partial updates that leave the other ranges intact.

// File: rtl/lcd_ld_pkg.sv
package lcd_ld_pkg;

    typedef enum logic [1:0] {
        ADDR_WAIT = 2'd0,
        CAPTURE   = 2'd1,
        DISCARD   = 2'd2,
        COMMIT    = 2'd3
    } ld_state_e;

endpackage

// File: rtl/ld_sync.sv
module ld_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= raw_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;

endmodule

// File: rtl/ld_shift.sv
module ld_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] sh_q;

    // new bit enters at the top, so after W shifts the first bit sits at 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clr_i) begin
            sh_q <= '0;
        end else if (shift_i) begin
            sh_q <= {bit_i, sh_q[W-1:1]};
        end
    end

    assign q_o = sh_q;

endmodule

// File: rtl/ld_capture.sv
module ld_capture #(
    parameter int CHUNK_W = 64,
    parameter int KEEP_W  = 60,
    parameter int ID_W    = 2,
    parameter int CNT_W   = $clog2(CHUNK_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [KEEP_W-1:0] body_o,
    output logic [ID_W-1:0]   id_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam int ID_LSB  = CHUNK_W - ID_W;
    localparam int CNT_SAT = CHUNK_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [KEEP_W-1:0] body_q;
    logic [ID_W-1:0]   id_q;

    // saturating count of received bits; one past CHUNK_W marks an overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (shift_i && (cnt_q != CNT_W'(CNT_SAT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // indexed write: only positions the store uses are kept, padding is dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_q <= '0;
            id_q   <= '0;
        end else if (shift_i) begin
            for (int k = 0; k < KEEP_W; k++) begin
                if (cnt_q == CNT_W'(k)) begin
                    body_q[k] <= bit_i;
                end
            end
            for (int j = 0; j < ID_W; j++) begin
                if (cnt_q == CNT_W'(ID_LSB + j)) begin
                    id_q[j] <= bit_i;
                end
            end
        end
    end

    assign body_o = body_q;
    assign id_o   = id_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/ld_store.sv
module ld_store #(
    parameter int SEG_BITS   = 204,
    parameter int SLICE_W    = 52,
    parameter int NUM_CHUNKS = 4,
    parameter int ID_W       = 2,
    parameter int CTL_W      = 8,
    parameter int KEEP_W     = SLICE_W + CTL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_i,
    input  logic [KEEP_W-1:0]   body_i,
    input  logic [ID_W-1:0]     id_i,
    output logic [SEG_BITS-1:0] disp_o,
    output logic [CTL_W-1:0]    ctl_o
);

    logic [CTL_W-1:0] ctl_q;

    for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_slice
        localparam int LO   = g * SLICE_W;
        localparam int REST = SEG_BITS - LO;
        localparam int SW   = (REST < SLICE_W) ? REST : SLICE_W;

        logic [SW-1:0] seg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q <= '0;
            end else if (commit_i && (id_i == ID_W'(g))) begin
                seg_q <= body_i[SW-1:0];
            end
        end

        assign disp_o[LO +: SW] = seg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (commit_i && (id_i == '0)) begin
            ctl_q <= body_i[SLICE_W +: CTL_W];
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/lcd_serial_loader.sv
module lcd_serial_loader
    import lcd_ld_pkg::*;
#(
    parameter int              SEG_BITS   = 204,
    parameter int              SLICE_W    = 52,
    parameter int              NUM_CHUNKS = 4,
    parameter int              CHUNK_W    = 64,
    parameter int              ID_W       = 2,
    parameter int              CTL_W      = 8,
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h41
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    output logic [SEG_BITS-1:0] disp_o,
    output logic                cur_low_o,
    output logic [3:0]          port_sel_o,
    output logic                bias_half_o,
    output logic                seg_off_o,
    output logic                save_mode_o
);

    localparam int KEEP_W  = SLICE_W + CTL_W;
    localparam int D_CNT_W = $clog2(CHUNK_W + 2);

    logic [2:0]         sync_w;
    logic               ce_s, sclk_s, sdi_s;
    logic               ce_d, sclk_d;
    logic               ce_rise, ce_fall, sclk_rise;

    ld_state_e          st_q, st_d;
    logic               addr_shift, addr_clr;
    logic               data_shift, data_clr;
    logic               commit;

    logic [ADDR_W-1:0]  addr_q;
    logic [KEEP_W-1:0]  body_w;
    logic [ID_W-1:0]    id_w;
    logic [D_CNT_W-1:0] data_cnt;
    logic [CTL_W-1:0]   ctl_w;

    ld_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({ce_i, sclk_i, sdi_i}),
        .sync_o (sync_w)
    );

    assign ce_s   = sync_w[2];
    assign sclk_s = sync_w[1];
    assign sdi_s  = sync_w[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_d   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            ce_d   <= ce_s;
            sclk_d <= sclk_s;
        end
    end

    assign ce_rise   = ce_s & ~ce_d;
    assign ce_fall   = ~ce_s & ce_d;
    assign sclk_rise = sclk_s & ~sclk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ADDR_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ADDR_WAIT: begin
                if (ce_rise) begin
                    st_d = (addr_q == DEV_ADDR) ? CAPTURE : DISCARD;
                end
            end
            CAPTURE: begin
                if (ce_fall) begin
                    st_d = COMMIT;
                end
            end
            DISCARD: begin
                if (ce_fall) begin
                    st_d = ADDR_WAIT;
                end
            end
            COMMIT: begin
                st_d = ADDR_WAIT;
            end
        endcase
    end

    // per-state controls
    always_comb begin
        addr_shift = 1'b0;
        addr_clr   = ce_fall;
        data_shift = 1'b0;
        data_clr   = ce_rise;
        commit     = 1'b0;
        unique case (st_q)
            ADDR_WAIT: addr_shift = sclk_rise & ~ce_s;
            CAPTURE:   data_shift = sclk_rise & ce_s;
            DISCARD:   ;
            COMMIT:    commit = (data_cnt == D_CNT_W'(CHUNK_W));
        endcase
    end

    ld_shift #(.W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (addr_clr),
        .shift_i (addr_shift),
        .bit_i   (sdi_s),
        .q_o     (addr_q)
    );

    ld_capture #(
        .CHUNK_W (CHUNK_W),
        .KEEP_W  (KEEP_W),
        .ID_W    (ID_W),
        .CNT_W   (D_CNT_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (data_clr),
        .shift_i (data_shift),
        .bit_i   (sdi_s),
        .body_o  (body_w),
        .id_o    (id_w),
        .cnt_o   (data_cnt)
    );

    ld_store #(
        .SEG_BITS   (SEG_BITS),
        .SLICE_W    (SLICE_W),
        .NUM_CHUNKS (NUM_CHUNKS),
        .ID_W       (ID_W),
        .CTL_W      (CTL_W),
        .KEEP_W     (KEEP_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .body_i   (body_w),
        .id_i     (id_w),
        .disp_o   (disp_o),
        .ctl_o    (ctl_w)
    );

    assign cur_low_o   = ctl_w[0];
    assign port_sel_o  = ctl_w[4:1];
    assign bias_half_o = ctl_w[5];
    assign seg_off_o   = ctl_w[6];
    assign save_mode_o = ctl_w[7];

endmodule

// File: rtl/ld_checker.sv
module ld_checker
    import lcd_ld_pkg::*;
#(
    parameter int SEG_BITS = 204,
    parameter int SLICE_W  = 52,
    parameter int CHUNK_W  = 64,
    parameter int CTL_W    = 8,
    parameter int ID_W     = 2,
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h41,
    parameter int CNT_W    = $clog2(CHUNK_W + 2)
) (
    input logic                        clk,
    input logic                        rst_n,
    input ld_state_e                   st_q,
    input logic [ADDR_W-1:0]           addr_q,
    input logic [CNT_W-1:0]            data_cnt,
    input logic [ID_W-1:0]             id_w,
    input logic [SLICE_W+CTL_W-1:0]    body_w,
    input logic [SEG_BITS-1:0]         disp_o,
    input logic [CTL_W-1:0]            ctl_w
);

    AST_HOLD_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != COMMIT) |=> ($stable(disp_o) && $stable(ctl_w))); // R7

    AST_SHORT_OR_LONG_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == COMMIT && data_cnt != CNT_W'(CHUNK_W)) |=> ($stable(disp_o) && $stable(ctl_w))); // R5

    AST_CAPTURE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAPTURE && $past(st_q) == ADDR_WAIT) |-> ($past(addr_q) == DEV_ADDR)); // R2

    AST_CHUNK0_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == COMMIT && data_cnt == CNT_W'(CHUNK_W) && id_w == '0)
        |=> (ctl_w == $past(body_w[SLICE_W +: CTL_W]))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (data_cnt <= CNT_W'(CHUNK_W + 1))); // R3

endmodule

bind lcd_serial_loader ld_checker #(
    .SEG_BITS (SEG_BITS),
    .SLICE_W  (SLICE_W),
    .CHUNK_W  (CHUNK_W),
    .CTL_W    (CTL_W),
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR),
    .CNT_W    (D_CNT_W)
) u_ld_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_q     (st_q),
    .addr_q   (addr_q),
    .data_cnt (data_cnt),
    .id_w     (id_w),
    .body_w   (body_w),
    .disp_o   (disp_o),
    .ctl_w    (ctl_w)
);

// File: tb/tb_lcd_serial_loader.sv
module tb_lcd_serial_loader;

    localparam int HALF = 20;  // serial half period in system cycles (160 ns)

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce_i = 1'b0;
    logic         sclk_i = 1'b0;
    logic         sdi_i = 1'b0;
    logic [203:0] disp_o;
    logic         cur_low_o, bias_half_o, seg_off_o, save_mode_o;
    logic [3:0]   port_sel_o;

    always #4 clk = ~clk;

    lcd_serial_loader dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_i        (ce_i),
        .sclk_i      (sclk_i),
        .sdi_i       (sdi_i),
        .disp_o      (disp_o),
        .cur_low_o   (cur_low_o),
        .port_sel_o  (port_sel_o),
        .bias_half_o (bias_half_o),
        .seg_off_o   (seg_off_o),
        .save_mode_o (save_mode_o)
    );

    typedef struct {
        logic [203:0] ram;
        logic [7:0]   ctl;
        string        req;
    } sb_item_t;

    sb_item_t     sb[$];
    logic [203:0] exp_ram = '0;
    logic [7:0]   exp_ctl = '0;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    function automatic logic [7:0] act_ctl();
        return {save_mode_o, seg_off_o, bias_half_o, port_sel_o, cur_low_o};
    endfunction

    task automatic check_now(input string req);
        n_chk++;
        if (disp_o !== exp_ram) begin
            n_bad++;
            $display("FAIL %s segments act=%h exp=%h", req, disp_o, exp_ram);
        end
        n_chk++;
        if (act_ctl() !== exp_ctl) begin
            n_bad++;
            $display("FAIL %s settings act=%h exp=%h", req, act_ctl(), exp_ctl);
        end
    endtask

    function automatic logic [63:0] mk_frame(input logic [1:0] id, input logic [51:0] data,
                                             input logic [7:0] ctl, input logic [1:0] pad);
        return {id, pad, ctl, data};
    endfunction

    task automatic ser_bit(input logic b, input bit idle_high);
        @(negedge clk) sdi_i = b;
        repeat (HALF) @(negedge clk);
        sclk_i = idle_high ? 1'b0 : 1'b1;
        repeat (HALF) @(negedge clk);
        sclk_i = idle_high ? 1'b1 : 1'b0;
    endtask

    // drive one transfer, update the model, push the expectation
    task automatic send_frame(input logic [7:0] addr, input bit with_addr,
                              input logic [63:0] fr, input int nbits,
                              input bit idle_high, input string req);
        bit ok;
        @(negedge clk) sclk_i = idle_high;
        repeat (HALF) @(negedge clk);
        if (with_addr) begin
            for (int i = 0; i < 8; i++) ser_bit(addr[i], idle_high);
        end
        repeat (HALF) @(negedge clk);
        ce_i = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_bit((i < 64) ? fr[i] : 1'b0, idle_high);
            if (i == 31) check_now("R7 mid-burst hold");
        end
        repeat (HALF) @(negedge clk);
        ce_i = 1'b0;
        repeat (HALF) @(negedge clk);
        ok = with_addr && (addr == 8'h41) && (nbits == 64);
        if (ok) begin
            case (fr[63:62])
                2'd0: begin exp_ram[51:0] = fr[51:0]; exp_ctl = fr[59:52]; end
                2'd1: exp_ram[103:52]  = fr[51:0];
                2'd2: exp_ram[155:104] = fr[51:0];
                default: exp_ram[203:156] = fr[47:0];
            endcase
        end
        sb.push_back('{ram: exp_ram, ctl: exp_ctl, req: req});
    endtask

    // monitor: pops expectations once the design has had time to commit
    initial begin
        sb_item_t it;
        forever begin
            wait (sb.size() != 0);
            repeat (16) @(negedge clk);
            it = sb.pop_front();
            n_chk++;
            if (disp_o !== it.ram) begin
                n_bad++;
                $display("FAIL %s segments act=%h exp=%h", it.req, disp_o, it.ram);
            end
            n_chk++;
            if (act_ctl() !== it.ctl) begin
                n_bad++;
                $display("FAIL %s settings act=%h exp=%h", it.req, act_ctl(), it.ctl);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_now("R1 reset state");

        // R3 R4: every chunk number, resting-low clock
        send_frame(8'h41, 1, mk_frame(2'd0, 52'hA_5C3F_0E91_D27B, 8'hA5, 2'b00), 64, 0, "R3 R4 chunk0");
        send_frame(8'h41, 1, mk_frame(2'd1, 52'h3_9F17_44C0_8E6A, 8'h00, 2'b00), 64, 0, "R4 chunk1");
        send_frame(8'h41, 1, mk_frame(2'd2, 52'hC_0FFE_E123_4567, 8'h00, 2'b00), 64, 0, "R4 chunk2");
        // R4: chunk 3 with set padding and set bits 51:48 that must be ignored
        send_frame(8'h41, 1, mk_frame(2'd3, 52'hF_B00B_1E55_AA33, 8'hFF, 2'b11), 64, 0, "R4 chunk3 padding");

        // R2: foreign addresses
        send_frame(8'h42, 1, mk_frame(2'd0, 52'h1_1111_1111_1111, 8'h3C, 2'b00), 64, 0, "R2 address 0x42");
        send_frame(8'h82, 1, mk_frame(2'd1, 52'h2_2222_2222_2222, 8'h00, 2'b00), 64, 0, "R2 address 0x82 bit order");

        // R5: wrong lengths
        send_frame(8'h41, 1, mk_frame(2'd0, 52'h5_5555_5555_5555, 8'hFF, 2'b00), 63, 0, "R5 63 bits");
        send_frame(8'h41, 1, mk_frame(2'd2, 52'h6_6666_6666_6666, 8'h00, 2'b00), 65, 0, "R5 65 bits");

        // R9: burst without a fresh address phase
        send_frame(8'h41, 0, mk_frame(2'd0, 52'h7_7777_7777_7777, 8'h81, 2'b00), 64, 0, "R9 no address");

        // R8: resting-high clock, including the switch from resting low
        send_frame(8'h41, 1, mk_frame(2'd1, 52'h8_1234_5678_9ABC, 8'h00, 2'b00), 64, 1, "R8 idle high chunk1");
        send_frame(8'h41, 1, mk_frame(2'd0, 52'h9_DEAD_BEEF_0001, 8'h5A, 2'b10), 64, 1, "R8 idle high chunk0");
        send_frame(8'h42, 1, mk_frame(2'd3, 52'hE_EEEE_EEEE_EEEE, 8'h00, 2'b00), 64, 1, "R8 R2 idle high foreign");

        // R6: partial update with chunk 0 only, back on resting-low clock
        send_frame(8'h41, 1, mk_frame(2'd0, 52'h0_0F0F_F0F0_3C3C, 8'h3E, 2'b00), 64, 0, "R6 chunk0 only");

        wait (sb.size() == 0);
        repeat (30) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule